// File: doc/BRIEF.md
# Reset Configuration Word Sampler

This block captures a 32-bit hardware configuration word while the chip is held in hard reset. The word comes either from the external data bus or from an all-zeros internal default. A configuration strobe, active low, makes the choice at each sampling instant. While hard reset stays asserted, the block takes a fresh sample on a fixed interval of clock cycles. It ignores samples until the bus has had time to settle after reset entry. When hard reset is released, the last accepted word is frozen and a valid flag rises.

Power-on reset is the asynchronous reset of the block. While it is low, the output holds the default word with the valid flag low, and the block then behaves as if hard reset were active. Hard reset, the strobe and the data bus each pass through a two-flop synchronizer before any logic uses them. A new hard reset entry clears the word to the default, drops the valid flag and restarts both cycle counters.

Top module: `rcw_sampler`

## Requirements
- R1: While rst_ni is low, cfg_word_o is 32'h00000000 and cfg_valid_o is 0. This also holds when rst_ni falls in the middle of operation.
- R2: At an accepted sample, cfg_word_o takes the synchronized data bus if the synchronized cfg_strobe_ni is 0. If it is 1, cfg_word_o takes 32'h00000000.
- R3: While hard reset is held, samples occur every 9 clock edges. They fall on edges k = 9, 18, 27, ... counted from the reset entry edge (k = 0).
- R4: A sample is accepted only after the 15-cycle settle counter has saturated, so the first accepted sample is at k = 18. The word changes on no other edge, apart from a reset entry.
- R5: On the edge where a newly asserted hard reset reaches the logic, cfg_valid_o goes to 0 and cfg_word_o goes to 32'h00000000.
- R6: When released hard reset reaches the logic, cfg_valid_o goes to 1 on that edge.
- R7: hreset_ni, cfg_strobe_ni and data_i are active-low/raw inputs seen through two flops. A change driven before edge n acts on the logic at edge n+2, so outputs change after edge n+2.
- R8: If hard reset is released before the first accepted sample, cfg_word_o is 32'h00000000 and cfg_valid_o is 1.
- R9: While hard reset is not active, changes on data_i and cfg_strobe_ni leave cfg_word_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| hreset_ni | input | 1 | Hard reset request, active low |
| cfg_strobe_ni | input | 1 | Configuration strobe, active low: 0 selects the data bus |
| data_i | input | 32 | External data bus |
| cfg_word_o | output | 32 | Latched configuration word |
| cfg_valid_o | output | 1 | Word frozen after hard reset release |

## Verification
The hardest case to reach is the boundary of the settle window. A sample at k = 9 must be discarded, while the sample at k = 18 must be taken. Both are counted from an entry edge that lies two synchronizer stages behind the pin. The stimulus holds hard reset with the strobe low and a distinctive bus value, then checks the word on both sides of the k = 18 edge. It changes the bus and the strobe between later ticks to tell consecutive samples apart. A hard reset released at k below 18 exercises the path that freezes the default word.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  parameter int unsigned CFG_W = 32;
  typedef logic [CFG_W-1:0] cfg_word_t;
  localparam cfg_word_t CFG_DEFAULT = '0;
endpackage

// File: rtl/rcw_sync.sv
module rcw_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rcw_timer.sv
module rcw_timer #(
  parameter int unsigned PERIOD = 9,
  parameter int unsigned SETTLE = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic restart_i,
  output logic tick_o,
  output logic settled_o
);
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned ST_W = $clog2(SETTLE + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [ST_W-1:0] ST_MAX  = ST_W'(SETTLE);

  logic [PH_W-1:0] ph_q;
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      st_q <= '0;
    end else if (restart_i) begin
      ph_q <= '0;
      st_q <= '0;
    end else if (active_i) begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (st_q != ST_MAX) st_q <= st_q + 1'b1;
    end
  end

  assign tick_o    = active_i && !restart_i && (ph_q == PH_LAST);
  assign settled_o = (st_q == ST_MAX);
endmodule

// File: rtl/rcw_capture.sv
module rcw_capture
  import rcw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      rel_i,
  input  logic      tick_i,
  input  logic      settled_i,
  input  logic      strobe_ni,
  input  cfg_word_t data_i,
  output cfg_word_t word_o,
  output logic      valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= CFG_DEFAULT;
      valid_o <= 1'b0;
    end else if (restart_i) begin
      word_o  <= CFG_DEFAULT;
      valid_o <= 1'b0;
    end else if (tick_i && settled_i) begin
      word_o <= strobe_ni ? CFG_DEFAULT : data_i;
    end else if (rel_i) begin
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rcw_sampler.sv
module rcw_sampler
  import rcw_pkg::*;
#(
  parameter int unsigned SAMPLE_PERIOD = 9,
  parameter int unsigned SETTLE_CYCLES = 15,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hreset_ni,
  input  logic             cfg_strobe_ni,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_word_o,
  output logic             cfg_valid_o
);
  logic      hr_s, strobe_s;
  cfg_word_t data_s;
  logic      hr_act, prev_act, restart, rel_ev, tick, settled;

  // reset value 0: power-on reset implies hard reset
  rcw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hr (
    .clk_i, .rst_ni, .d_i(hreset_ni), .q_o(hr_s));
  rcw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_st (
    .clk_i, .rst_ni, .d_i(cfg_strobe_ni), .q_o(strobe_s));
  rcw_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_DEFAULT)) u_sync_d (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s));

  assign hr_act = !hr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_act <= 1'b1;
    else         prev_act <= hr_act;
  end

  assign restart = hr_act && !prev_act;
  assign rel_ev  = !hr_act && prev_act;

  rcw_timer #(.PERIOD(SAMPLE_PERIOD), .SETTLE(SETTLE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .active_i(hr_act), .restart_i(restart),
    .tick_o(tick), .settled_o(settled));

  rcw_capture u_capture (
    .clk_i, .rst_ni, .restart_i(restart), .rel_i(rel_ev), .tick_i(tick),
    .settled_i(settled), .strobe_ni(strobe_s), .data_i(data_s),
    .word_o(cfg_word_o), .valid_o(cfg_valid_o));
endmodule

// File: rtl/rcw_sampler_chk.sv
module rcw_sampler_chk
  import rcw_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      hr_act,
  input logic      restart,
  input logic      rel_ev,
  input logic      tick,
  input logic      settled,
  input logic      strobe_s,
  input cfg_word_t data_s,
  input cfg_word_t cfg_word_o,
  input logic      cfg_valid_o
);
  assert_entry_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (!cfg_valid_o && cfg_word_o == CFG_DEFAULT));

  assert_sample_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && settled) |=> cfg_word_o == ($past(strobe_s) ? CFG_DEFAULT : $past(data_s)));

  assert_release_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_ev |=> cfg_valid_o);

  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_o && !hr_act) |=> $stable(cfg_word_o));

  assert_tick_in_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> hr_act);

  assert_change_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_word_o) |-> ($past(tick && settled) || $past(restart)));
endmodule

bind rcw_sampler rcw_sampler_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hr_act(hr_act), .restart(restart),
  .rel_ev(rel_ev), .tick(tick), .settled(settled), .strobe_s(strobe_s),
  .data_s(data_s), .cfg_word_o(cfg_word_o), .cfg_valid_o(cfg_valid_o));

// File: tb/rcw_sampler_bench.sv
module rcw_sampler_bench;
  logic        clk = 1'b0;
  logic        rst_ni, hreset_ni, cfg_strobe_ni;
  logic [31:0] data_i;
  logic [31:0] cfg_word_o;
  logic        cfg_valid_o;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rcw_sampler u_rcw_sampler (
    .clk_i(clk), .rst_ni(rst_ni), .hreset_ni(hreset_ni),
    .cfg_strobe_ni(cfg_strobe_ni), .data_i(data_i),
    .cfg_word_o(cfg_word_o), .cfg_valid_o(cfg_valid_o));

  // reference model: inputs delayed two edges (R7), entry/release per spec
  bit          hq[$];
  bit          sq[$];
  logic [31:0] dq[$];
  int          k;
  bit          m_prev, m_valid;
  logic [31:0] m_word;

  task automatic model_reset();
    hq = '{1'b0, 1'b0};
    sq = '{1'b1, 1'b1};
    dq = '{32'h0, 32'h0};
    k = 0; m_prev = 1'b1; m_valid = 1'b0; m_word = 32'h0;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      model_reset();
    end else begin
      bit act;
      act = !hq[0];
      if (act && !m_prev) begin
        k = 0; m_word = 32'h0; m_valid = 1'b0;
      end else if (act) begin
        k++;
        if (k >= 18 && (k % 9) == 0) m_word = sq[0] ? 32'h0 : dq[0];
      end else if (m_prev) begin
        m_valid = 1'b1;
      end
      m_prev = act;
      void'(hq.pop_front()); hq.push_back(hreset_ni);
      void'(sq.pop_front()); sq.push_back(cfg_strobe_ni);
      void'(dq.pop_front()); dq.push_back(data_i);
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (cfg_word_o !== m_word || cfg_valid_o !== m_valid) begin
      n_bad++;
      $display("FAIL %s model: word %h/%b exp %h/%b", cur_req,
               cfg_word_o, cfg_valid_o, m_word, m_valid);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; hreset_ni = 1'b0; cfg_strobe_ni = 1'b1; data_i = 32'hDEADBEEF;
    cur_req = "R1";
    wait_n(3);
    chk("R1", cfg_word_o, 32'h0);
    chk("R1", {31'b0, cfg_valid_o}, 32'h0);
    rst_ni = 1'b1;
    cur_req = "R2";
    for (int i = 0; i < 30; i++) begin
      data_i = 32'h1000_0000 + i;
      wait_n(1);
    end
    chk("R2", cfg_word_o, 32'h0);

    cur_req = "R6";
    hreset_ni = 1'b1;
    wait_n(2);
    chk("R7", {31'b0, cfg_valid_o}, 32'h0);
    wait_n(1);
    chk("R6", {31'b0, cfg_valid_o}, 32'h1);

    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin
      data_i = 32'h5555_0000 ^ (i * 32'h0101);
      cfg_strobe_ni = i[0];
      wait_n(1);
    end
    chk("R9", cfg_word_o, 32'h0);

    cur_req = "R5";
    cfg_strobe_ni = 1'b0; data_i = 32'hA5A5A5A5; hreset_ni = 1'b0;
    wait_n(2);
    chk("R7", {31'b0, cfg_valid_o}, 32'h1);
    wait_n(1);
    chk("R5", {31'b0, cfg_valid_o}, 32'h0);
    cur_req = "R4";
    wait_n(17);
    chk("R4", cfg_word_o, 32'h0);
    wait_n(1);
    chk("R4", cfg_word_o, 32'hA5A5A5A5);
    cur_req = "R3";
    data_i = 32'h12345678;
    wait_n(8);
    chk("R3", cfg_word_o, 32'hA5A5A5A5);
    wait_n(1);
    chk("R3", cfg_word_o, 32'h12345678);
    cur_req = "R2";
    cfg_strobe_ni = 1'b1;
    wait_n(9);
    chk("R2", cfg_word_o, 32'h0);
    cfg_strobe_ni = 1'b0; data_i = 32'hCAFEF00D;
    wait_n(9);
    chk("R2", cfg_word_o, 32'hCAFEF00D);
    cur_req = "R6";
    hreset_ni = 1'b1;
    wait_n(3);
    chk("R6", {31'b0, cfg_valid_o}, 32'h1);
    cur_req = "R9";
    for (int i = 0; i < 15; i++) begin
      data_i = ~data_i; cfg_strobe_ni = ~cfg_strobe_ni;
      wait_n(1);
    end
    chk("R9", cfg_word_o, 32'hCAFEF00D);

    cur_req = "R8";
    cfg_strobe_ni = 1'b0; data_i = 32'hFFFFFFFF; hreset_ni = 1'b0;
    wait_n(10);
    hreset_ni = 1'b1;
    wait_n(4);
    chk("R8", cfg_word_o, 32'h0);
    chk("R8", {31'b0, cfg_valid_o}, 32'h1);

    cur_req = "R7";
    hreset_ni = 1'b0;
    wait_n(1);
    hreset_ni = 1'b1;
    wait_n(6);
    chk("R7", {31'b0, cfg_valid_o}, 32'h1);

    cur_req = "R1";
    hreset_ni = 1'b0; data_i = 32'h0F0F0F0F;
    wait_n(25);
    hreset_ni = 1'b1;
    wait_n(4);
    chk("R1", cfg_word_o, 32'h0F0F0F0F);
    #2 rst_ni = 1'b0;
    wait_n(1);
    chk("R1", cfg_word_o, 32'h0);
    chk("R1", {31'b0, cfg_valid_o}, 32'h0);
    rst_ni = 1'b1;
    wait_n(6);
    chk("R1", {31'b0, cfg_valid_o}, 32'h1);

    summary();
    $finish;
  end
endmodule